// File: doc/BRIEF.md
# Multi-Lane Flash Phase Shifter

This block serializes one serial-flash transaction over one, two or four data lines. A sequencer hands it a command byte, an address, a dummy count, a byte count, a direction and two 3-bit interface-type codes. The block then walks through the command, address, dummy and data phases, one line-group per clock. Every clock of the block is one flash clock. The code picked for the transfer sets how many lines carry the address and how many carry the data. The command byte always goes out on a single line.

Write data is pulled from the sequencer one byte at a time through a take strobe. Read data is assembled from the sampled lines and handed back one byte at a time with a valid pulse. The block drives the output enables of the bidirectional IO lines. It releases every enable from the first dummy clock until the last read clock, so the flash can turn the bus around. Chip-select timing, register decoding and buffering belong to the surrounding controller.

The states are IDLE, CMD, ADDR, DUMMY, DATA and DONE:
- IDLE→CMD on start.
- CMD→ADDR after eight clocks.
- ADDR→DUMMY when a read has a non-zero dummy count. Otherwise ADDR→DATA when the byte count is non-zero, and ADDR→DONE when it is zero.
- DUMMY→DATA, or DUMMY→DONE for a zero byte count.
- DATA→DATA at each byte boundary, and DATA→DONE after the final byte.
- DONE→IDLE always.

Top module: `flash_lane_shifter`

## Requirements
- R1: During and after reset (rst_n low, asynchronous), and whenever the block is idle: busy=0, done=0, io_oe=0, rd_valid=0 and wr_take=0.
- R2: A start pulse seen in IDLE latches every transfer input. In the following eight clocks the command byte goes out MSB first on IO0 with io_oe=4'b0001, whatever the interface code.
- R3: Interface codes set the address and data line counts as follows. Code 0 uses 1 and 1. Code 1 uses 1 and 2. Code 2 uses 2 and 2. Code 3 uses 1 and 4. Code 4 uses 4 and 4. Codes 5, 6 and 7 behave as code 0. When 1, 2 or 4 lines are driven, io_oe is 4'b0001, 4'b0011 or 4'b1111.
- R4: The address phase sends addr[31:0] when addr4=1 and addr[23:0] when addr4=0, MSB first. It takes 32/n or 24/n clocks, where n is the address line count.
- R5: Within one clock the higher-numbered line carries the more significant bit. In single-line mode output is on IO0. With two lines, IO1 carries the more significant bit and IO0 the less. With four lines, IO3..IO0 carry a nibble, high nibble first.
- R6: A read with dummy_units=d spends 8*d clocks in the dummy phase with io_oe=0. dummy_units is ignored for program transfers.
- R7: During read data io_oe=0. Input is sampled on IO1 alone in single-line mode, on IO1:IO0 with two lines and on IO3:IO0 with four. Each byte is assembled MSB first. rd_valid pulses for one clock, with rd_byte, in the clock after the byte's last line-group.
- R8: During write data wr_take is high in exactly the clocks in which wr_byte is consumed. Bytes are consumed in order and each goes out over 8/n clocks, where n is the data line count.
- R9: A read uses rd_if_code and a program transfer uses wr_if_code.
- R10: With data_len=0 there is no data phase. DONE follows the address phase, or the dummy phase on a read.
- R11: busy is high from the clock after start through the DONE clock. done is high for exactly one clock, the one after the last shift clock, and the block is then idle.
- R12: A start pulse while busy is ignored, and so are changes on the transfer inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one flash clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted in IDLE only) |
| is_read | input | 1 | 1 = read transfer, 0 = program transfer |
| rd_if_code | input | 3 | Interface code used for reads |
| wr_if_code | input | 3 | Interface code used for program transfers |
| cmd_byte | input | 8 | Command byte |
| addr | input | 32 | Flash address |
| addr4 | input | 1 | 1 = 4-byte address, 0 = 3-byte address |
| dummy_units | input | DUMMY_W | Dummy clocks divided by eight (reads only) |
| data_len | input | LEN_W | Number of data bytes |
| wr_byte | input | 8 | Write data byte offered by the sequencer |
| wr_take | output | 1 | wr_byte is consumed at the end of this clock |
| rd_byte | output | 8 | Assembled read byte |
| rd_valid | output | 1 | rd_byte is valid this clock |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| io_in | input | 4 | Sampled IO lines |
| io_out | output | 4 | Values driven on IO lines |
| io_oe | output | 4 | Output enables of IO lines |

## Verification
The assertions take for granted that start is pulsed from IDLE and that wr_byte is steady while wr_take is high. They also assume rst_n is the only way to cut a transfer short. The stimulus keeps to this: inputs change only at falling edges, start lasts one clock except in the deliberate busy-time pulse, and the write byte advances only on the rising edge that follows wr_take. Read data is driven on the lines from the bench's own count of command, address and dummy clocks. Unused lines carry noise so that a wrong sampling line shows up in the assembled byte.

// File: rtl/fls_pkg.sv
`timescale 1ns/1ps
package fls_pkg;
    localparam int ADDR_BITS = 32;

    typedef enum logic [1:0] {
        LW1 = 2'd0,
        LW2 = 2'd1,
        LW4 = 2'd2
    } lane_w_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_DUMMY,
        S_DATA,
        S_DONE
    } phase_t;

    function automatic logic [3:0] lane_mask(input lane_w_t w);
        unique case (w)
            LW1:     return 4'b0001;
            LW2:     return 4'b0011;
            LW4:     return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction
endpackage

// File: rtl/fls_lane_decode.sv
`timescale 1ns/1ps
module fls_lane_decode
    import fls_pkg::*;
(
    input  logic [2:0] if_code,
    output lane_w_t    addr_w,
    output lane_w_t    data_w
);
    always_comb begin
        unique case (if_code)
            3'd1:    begin addr_w = LW1; data_w = LW2; end
            3'd2:    begin addr_w = LW2; data_w = LW2; end
            3'd3:    begin addr_w = LW1; data_w = LW4; end
            3'd4:    begin addr_w = LW4; data_w = LW4; end
            default: begin addr_w = LW1; data_w = LW1; end
        endcase
    end
endmodule

// File: rtl/fls_tx_map.sv
`timescale 1ns/1ps
module fls_tx_map
    import fls_pkg::*;
(
    input  logic [3:0] sh_top,
    input  lane_w_t    lw,
    input  logic       drive,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (drive) begin
            io_oe = lane_mask(lw);
            unique case (lw)
                LW2:     io_out = {2'b00, sh_top[3:2]};
                LW4:     io_out = sh_top;
                default: io_out = {3'b000, sh_top[3]};
            endcase
        end
    end
endmodule

// File: rtl/fls_rx_gather.sv
`timescale 1ns/1ps
module fls_rx_gather
    import fls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       last,
    input  lane_w_t    lw,
    input  logic [3:0] io_in,
    output logic [7:0] rd_byte,
    output logic       rd_valid
);
    logic [7:0] acc;
    logic [7:0] acc_nxt;

    always_comb begin
        unique case (lw)
            LW2:     acc_nxt = {acc[5:0], io_in[1:0]};
            LW4:     acc_nxt = {acc[3:0], io_in};
            default: acc_nxt = {acc[6:0], io_in[1]};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= 8'h00;
            rd_byte  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (en) begin
                acc <= acc_nxt;
                if (last) begin
                    rd_byte  <= acc_nxt;
                    rd_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/flash_lane_shifter.sv
`timescale 1ns/1ps
module flash_lane_shifter
    import fls_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int DUMMY_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_read,
    input  logic [2:0]         rd_if_code,
    input  logic [2:0]         wr_if_code,
    input  logic [7:0]         cmd_byte,
    input  logic [31:0]        addr,
    input  logic               addr4,
    input  logic [DUMMY_W-1:0] dummy_units,
    input  logic [LEN_W-1:0]   data_len,
    input  logic [7:0]         wr_byte,
    output logic               wr_take,
    output logic [7:0]         rd_byte,
    output logic               rd_valid,
    output logic               busy,
    output logic               done,
    input  logic [3:0]         io_in,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe
);
    localparam int DUM_MAX = ((1 << DUMMY_W) - 1) * 8;
    localparam int CNT_W   = $clog2((DUM_MAX > ADDR_BITS) ? DUM_MAX : ADDR_BITS);

    phase_t               state, nxt;
    logic [ADDR_BITS-1:0] sh;
    logic [ADDR_BITS-1:0] addr_r;
    logic [CNT_W-1:0]     cnt;
    logic [LEN_W-1:0]     bytes_left;
    logic [DUMMY_W-1:0]   dummy_r;
    logic                 rd_mode, addr4_r, last, load_wr, drive;
    lane_w_t              addr_w, data_w, dec_aw, dec_dw, cur_w;
    logic [2:0]           sel_code;

    assign sel_code = is_read ? rd_if_code : wr_if_code;
    assign last     = (cnt == '0);

    fls_lane_decode u_dec (
        .if_code (sel_code),
        .addr_w  (dec_aw),
        .data_w  (dec_dw)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_CMD;
            S_CMD:   if (last) nxt = S_ADDR;
            S_ADDR:  if (last) begin
                         if (dummy_r != '0)         nxt = S_DUMMY;
                         else if (bytes_left != '0) nxt = S_DATA;
                         else                       nxt = S_DONE;
                     end
            S_DUMMY: if (last) nxt = (bytes_left != '0) ? S_DATA : S_DONE;
            S_DATA:  if (last && bytes_left == LEN_W'(1)) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        load_wr = !rd_mode && (nxt == S_DATA) && (state != S_DATA || last);
    end

    // outputs
    always_comb begin
        unique case (state)
            S_ADDR:  cur_w = addr_w;
            S_DATA:  cur_w = data_w;
            default: cur_w = LW1;
        endcase
        drive   = (state == S_CMD) || (state == S_ADDR) ||
                  (state == S_DATA && !rd_mode);
        busy    = (state != S_IDLE);
        done    = (state == S_DONE);
        wr_take = load_wr;
    end

    // phase datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh         <= '0;
            addr_r     <= '0;
            cnt        <= '0;
            bytes_left <= '0;
            dummy_r    <= '0;
            rd_mode    <= 1'b0;
            addr4_r    <= 1'b0;
            addr_w     <= LW1;
            data_w     <= LW1;
        end else if (state == S_IDLE) begin
            if (start) begin
                rd_mode    <= is_read;
                addr_w     <= dec_aw;
                data_w     <= dec_dw;
                addr_r     <= addr;
                addr4_r    <= addr4;
                dummy_r    <= is_read ? dummy_units : '0;
                bytes_left <= data_len;
                sh         <= {cmd_byte, 24'h000000};
                cnt        <= CNT_W'(7);
            end
        end else begin
            sh  <= sh << (1 << cur_w);
            cnt <= cnt - 1'b1;
            if (last) begin
                case (nxt)
                    S_ADDR: begin
                        sh  <= addr4_r ? addr_r : {addr_r[23:0], 8'h00};
                        cnt <= CNT_W'(((addr4_r ? 32 : 24) >> addr_w) - 1);
                    end
                    S_DUMMY: cnt <= CNT_W'({dummy_r, 3'b000}) - 1'b1;
                    S_DATA: begin
                        cnt <= CNT_W'((8 >> data_w) - 1);
                        if (load_wr) sh <= {wr_byte, 24'h000000};
                        if (state == S_DATA) bytes_left <= bytes_left - 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    fls_tx_map u_tx (
        .sh_top (sh[ADDR_BITS-1 -: 4]),
        .lw     (cur_w),
        .drive  (drive),
        .io_out (io_out),
        .io_oe  (io_oe)
    );

    fls_rx_gather u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state == S_DATA && rd_mode),
        .last     (last),
        .lw       (data_w),
        .io_in    (io_in),
        .rd_byte  (rd_byte),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/fls_shift_checks.sv
`timescale 1ns/1ps
module fls_shift_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       rd_valid,
    input logic       wr_take,
    input logic [3:0] io_oe
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (io_oe == 4'b0000 && !done && !wr_take));

    assert_oe_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000 || io_oe == 4'b0001 || io_oe == 4'b0011 || io_oe == 4'b1111));

    assert_cmd_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && io_oe == 4'b0001));

    assert_rd_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (io_oe == 4'b0000));

    assert_take_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (io_oe != 4'b0000 && busy));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind flash_lane_shifter fls_shift_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rd_valid (rd_valid),
    .wr_take  (wr_take),
    .io_oe    (io_oe)
);

// File: tb/tb_flash_lane_shifter.sv
`timescale 1ns/1ps
module tb_flash_lane_shifter;
    typedef struct packed {
        logic        rd;
        logic [2:0]  rc;
        logic [2:0]  wc;
        logic [7:0]  cmd;
        logic [31:0] adr;
        logic        a4;
        logic [3:0]  dm;
        logic [7:0]  len;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 3'd0, 8'h03, 32'h00A1B2C3, 1'b0, 4'd0, 8'd3},
        '{1'b1, 3'd1, 3'd0, 8'h3B, 32'h00123456, 1'b0, 4'd1, 8'd2},
        '{1'b1, 3'd2, 3'd0, 8'hBB, 32'h00FEDCBA, 1'b0, 4'd1, 8'd2},
        '{1'b1, 3'd3, 3'd0, 8'h6B, 32'h89ABCDEF, 1'b1, 4'd1, 8'd4},
        '{1'b1, 3'd4, 3'd1, 8'hEB, 32'h55C0FFEE, 1'b0, 4'd2, 8'd3},
        '{1'b0, 3'd4, 3'd0, 8'h02, 32'h00000102, 1'b0, 4'd0, 8'd2},
        '{1'b0, 3'd0, 3'd3, 8'h32, 32'hDEADBEEF, 1'b1, 4'd3, 8'd3},
        '{1'b1, 3'd6, 3'd4, 8'h0B, 32'h00777777, 1'b0, 4'd1, 8'd1},
        '{1'b0, 3'd0, 3'd2, 8'h06, 32'h00ABCDEF, 1'b0, 4'd0, 8'd0},
        '{1'b1, 3'd4, 3'd0, 8'hEB, 32'h00102030, 1'b0, 4'd1, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_read = 1'b0;
    logic [2:0]  rd_if_code = 3'd0;
    logic [2:0]  wr_if_code = 3'd0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [31:0] addr = 32'h0;
    logic        addr4 = 1'b0;
    logic [3:0]  dummy_units = 4'd0;
    logic [13:0] data_len = 14'd0;
    logic [7:0]  wr_byte;
    logic        wr_take;
    logic [7:0]  rd_byte;
    logic        rd_valid;
    logic        busy;
    logic        done;
    logic [3:0]  io_in = 4'h0;
    logic [3:0]  io_out;
    logic [3:0]  io_oe;

    logic [7:0]  wbytes [16];
    logic [7:0]  rbytes [16];
    int          widx;
    logic        widx_clr = 1'b0;
    int          errors = 0;
    int          checks = 0;

    always #4 clk = ~clk;

    flash_lane_shifter dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .rd_if_code(rd_if_code), .wr_if_code(wr_if_code), .cmd_byte(cmd_byte),
        .addr(addr), .addr4(addr4), .dummy_units(dummy_units), .data_len(data_len),
        .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte), .rd_valid(rd_valid),
        .busy(busy), .done(done), .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
    );

    assign wr_byte = wbytes[widx[3:0]];
    always @(posedge clk) begin
        if (widx_clr)     widx <= 0;
        else if (wr_take) widx <= widx + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R3 line counts, computed from the requirement table
    function automatic int addr_lanes(input logic [2:0] c);
        case (c)
            3'd2:    return 2;
            3'd4:    return 4;
            default: return 1;
        endcase
    endfunction
    function automatic int data_lanes(input logic [2:0] c);
        case (c)
            3'd1, 3'd2: return 2;
            3'd3, 3'd4: return 4;
            default:    return 1;
        endcase
    endfunction

    task automatic run_txn(input vec_t v, input bit poke, input int seed);
        logic [2:0]  code;
        logic [31:0] aword, word;
        int al, dl, nb, n_ad, n_dm, gpb, total, off_d, L, g;
        int bad_k, act_v, exp_v, nrd, rd_bad, rd_act, rd_exp;
        logic [3:0] exp_oe, exp_out;
        bit stream_ok;
        for (int i = 0; i < 16; i++) begin
            wbytes[i] = 8'((seed * 37 + i * 19) ^ 8'h5A);
            rbytes[i] = 8'((seed * 53 + i * 29) ^ 8'hC3);
        end
        code  = v.rd ? v.rc : v.wc;               // R9
        al    = addr_lanes(code);
        dl    = data_lanes(code);
        nb    = v.a4 ? 32 : 24;
        aword = v.a4 ? v.adr : {8'h00, v.adr[23:0]};
        n_ad  = nb / al;
        n_dm  = v.rd ? 8 * int'(v.dm) : 0;        // R6
        gpb   = 8 / dl;
        off_d = 8 + n_ad + n_dm;
        total = off_d + int'(v.len) * gpb;

        @(negedge clk);
        is_read = v.rd; rd_if_code = v.rc; wr_if_code = v.wc;
        cmd_byte = v.cmd; addr = v.adr; addr4 = v.a4;
        dummy_units = v.dm; data_len = 14'(v.len);
        start = 1'b1; widx_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; widx_clr = 1'b0;
        stream_ok = 1'b1; bad_k = -1; act_v = 0; exp_v = 0;
        nrd = 0; rd_bad = 0; rd_act = 0; rd_exp = 0;
        for (int k = 0; k <= total; k++) begin
            if (poke && k == 3) begin
                start = 1'b1; cmd_byte = ~v.cmd; addr = ~v.adr; is_read = ~v.rd;
            end
            if (poke && k == 4) start = 1'b0;
            io_in = 4'b0110;
            exp_oe = 4'b0000; exp_out = 4'b0000;
            L = 0; word = 0; g = 0;
            if (k < 8) begin
                L = 1; word = {24'h0, v.cmd}; g = k; nb = 8;
            end else if (k < 8 + n_ad) begin
                L = al; word = aword; g = k - 8; nb = v.a4 ? 32 : 24;
            end else if (k >= off_d && k < total) begin
                g = (k - off_d) % gpb;
                if (v.rd) begin
                    logic [7:0] rb;
                    logic [3:0] val;
                    rb  = rbytes[(k - off_d) / gpb];
                    val = 4'((rb >> (8 - dl * (g + 1))) & ((1 << dl) - 1));
                    if (dl == 1)      io_in = {2'b00, val[0], ~val[0]};
                    else if (dl == 2) io_in = {2'b11, val[1:0]};
                    else              io_in = val;
                end else begin
                    L = dl; word = {24'h0, wbytes[(k - off_d) / gpb]}; nb = 8;
                end
            end
            if (L != 0) begin
                exp_oe  = 4'((1 << L) - 1);
                exp_out = 4'((word >> (nb - L * (g + 1))) & ((1 << L) - 1));
            end
            if (stream_ok && (io_oe !== exp_oe || (io_out & exp_oe) !== exp_out)) begin
                stream_ok = 1'b0; bad_k = k;
                act_v = {io_oe, io_out}; exp_v = {exp_oe, exp_out};
            end
            if (rd_valid) begin
                if (rd_bad == 0 && (nrd >= int'(v.len) || rd_byte !== rbytes[nrd])) begin
                    rd_bad = 1; rd_act = rd_byte; rd_exp = rbytes[nrd];
                end
                nrd++;
            end
            if (k == total) begin
                check(done === 1'b1 && busy === 1'b1, "R11 done in final clock",
                      {busy, done}, 3);
                check(io_oe === 4'b0000, "R11 enables released at done", io_oe, 0);
            end else if (k < total) begin
                if (done !== 1'b0 || busy !== 1'b1) begin
                    stream_ok = 1'b0; if (bad_k < 0) bad_k = k;
                end
            end
            @(negedge clk);
        end
        if (!stream_ok)
            $display("  stream mismatch at clock %0d of %0d (code %0d)", bad_k, total, code);
        check(stream_ok, "R2/R3/R4/R5/R6/R8 line stream (oe,out)", act_v, exp_v);
        if (v.rd) begin
            check(rd_bad == 0, "R7 read byte", rd_act, rd_exp);
            check(nrd == int'(v.len), "R7 read byte count", nrd, int'(v.len));
        end else begin
            check(widx == int'(v.len), "R8 write bytes taken", widx, int'(v.len));
        end
        check(busy === 1'b0 && done === 1'b0 && io_oe === 4'b0000,
              "R1 idle after transfer", {busy, done, io_oe}, 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1 reset state
        #1;
        check(busy === 1'b0 && io_oe === 4'b0000 && done === 1'b0, "R1 reset outputs",
              {busy, done, io_oe}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid === 1'b0 && wr_take === 1'b0 && busy === 1'b0, "R1 idle after reset",
              {rd_valid, wr_take, busy}, 0);

        // table walk: codes 0..4 and 6 (R3, R9), R4 widths, R6 dummy, R10 zero length
        for (int i = 0; i < NV; i++) run_txn(VECS[i], 1'b0, i + 1);

        // R12 start and input changes while busy ignored
        run_txn(VECS[4], 1'b1, 21);
        run_txn(VECS[6], 1'b1, 22);

        // R1 reset in the middle of a transfer
        @(negedge clk);
        is_read = 1'b1; rd_if_code = 3'd4; cmd_byte = 8'hEB; data_len = 14'd2;
        dummy_units = 4'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(busy === 1'b0 && io_oe === 4'b0000 && done === 1'b0,
              "R1 reset mid-transfer", {busy, done, io_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_txn(VECS[2], 1'b0, 30);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule